// File: doc/BRIEF.md
# Posit Decoder to Fixed-Field Internal Value

This block turns an N-bit posit into a floating-point value whose fields have fixed widths. Downstream adders, multipliers and accumulators can then work without parsing variable-length fields. The output carries a not-a-real flag and a sign bit. It also carries an implicit bit and a fraction, which together with the sign form a two's complement significand. A biased exponent follows, with guard and sticky bits that leave the block cleared for a later rounding stage. The unit does no arithmetic and no rounding.

A negative posit is never negated into sign-magnitude form. The regime run is counted on the raw bits. The combined regime/exponent value is bitwise inverted for negative inputs, and the fraction bits pass through unchanged. The significand `S I.F` then reads as `-2*S + I + F/2^Wf`. A positive power of two therefore comes out as `1 x 2^k`, and a negative power of two comes out as `-2 x 2^(k-1)`. The exponent is stored as an offset from the smallest exponent any encoding can need. That exponent belongs to the negative number closest to zero, so every biased value is non-negative.

The exponent-field width is Wes = log2(N/8). The fraction width is Wf = N - Wes - 3, and the exponent width is We = log2(N) + Wes + 1. The bias is (N-2)*2^Wes + 1. One register stage sits between the input word and the outputs.

Top module: `posit_decoder`

## Requirements
- R1: `out_nar` is 1 exactly for the input 1 followed by N-1 zeros; for that input S=1, I=0, F=0 and E=0.
- R2: The all-zero input gives nar=0, S=0, I=0, F=0 and E=0.
- R3: A non-zero input whose top bit is 0 gives S=0 and I=1.
- R4: An input whose top bit is 1, other than the R1 pattern, gives S=1 and I=0 (two's complement significand, never negated).
- R5: For every input other than zero and the R1 pattern, (-2*S + I + F/2^Wf) * 2^(E - bias) equals the posit's real value, with bias = (N-2)*2^Wes + 1, Wes = log2(N/8), Wf = N-Wes-3, We = log2(N)+Wes+1.
- R6: E never exceeds 2*(N-2)*2^Wes + 1.
- R7: `out_guard` and `out_sticky` are always 0.
- R8: `out_valid` in a cycle equals `in_valid` of the previous cycle (outside reset), and the results come out in input order.
- R9: While the synchronous active-high reset is held, `out_valid` is 0 from the first clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present |
| in_posit | input | N | Posit encoding |
| out_valid | output | 1 | Output fields are present |
| out_nar | output | 1 | Not-a-real flag |
| out_sign | output | 1 | Significand sign bit S |
| out_imp | output | 1 | Implicit bit I |
| out_frac | output | Wf | Fraction bits F |
| out_exp | output | We | Biased exponent E |
| out_guard | output | 1 | Guard bit, cleared |
| out_sticky | output | 1 | Sticky bit, cleared |

## Verification
A miscounted regime run, an uninverted exponent on a negative word, or a wrong bias shows up as a wrong real value. It appears one clock after the word enters. Every encoding is applied for N=16 and for N=8, so each run length and each sign is reached. A lost or extra valid shows up in the same cycle as a mismatch against the delayed input valid. It also shows up as a scoreboard that drains out of order.

// File: rtl/posit_dec_pkg.sv
package posit_dec_pkg;

    typedef enum logic [1:0] {
        PCLS_REGULAR = 2'd0,
        PCLS_ZERO    = 2'd1,
        PCLS_NAR     = 2'd2
    } pcls_e;

    function automatic int es_width(input int n);
        return $clog2(n / 8);
    endfunction

    function automatic int frac_width(input int n);
        return n - es_width(n) - 3;
    endfunction

    function automatic int exp_width(input int n);
        return $clog2(n) + es_width(n) + 1;
    endfunction

    // offset from the lowest exponent any encoding can produce
    function automatic int exp_bias(input int n);
        return (n - 2) * (1 << es_width(n)) + 1;
    endfunction

    function automatic int exp_max(input int n);
        return 2 * (n - 2) * (1 << es_width(n)) + 1;
    endfunction

    function automatic int run_width(input int w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/posit_special_detect.sv
module posit_special_detect
    import posit_dec_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] word,
    output pcls_e        cls
);
    logic tail_any;

    assign tail_any = |word[N-2:0];

    always_comb begin
        if (tail_any)         cls = PCLS_REGULAR;
        else if (word[N-1])   cls = PCLS_NAR;
        else                  cls = PCLS_ZERO;
    end
endmodule

// File: rtl/posit_run_counter.sv
module posit_run_counter
    import posit_dec_pkg::*;
#(
    parameter int W  = 15,
    localparam int CW = run_width(W)
) (
    input  logic [W-1:0]  vec,
    output logic          lead,
    output logic [CW-1:0] run_len
);
    logic stopped;

    assign lead = vec[W-1];

    // length of the leading run of identical bits, at least one
    always_comb begin
        run_len = '0;
        stopped = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!stopped) begin
                if (vec[i] == lead) run_len = run_len + CW'(1);
                else                stopped = 1'b1;
            end
        end
    end
endmodule

// File: rtl/posit_field_align.sv
module posit_field_align
    import posit_dec_pkg::*;
#(
    parameter int N = 16,
    localparam int WES = es_width(N),
    localparam int WF  = frac_width(N),
    localparam int WE  = exp_width(N),
    localparam int CW  = run_width(N - 1)
) (
    input  logic          sign,
    input  logic          lead,
    input  logic [CW-1:0] run_len,
    input  logic [N-4:0]  tail,
    output logic [WF-1:0] frac,
    output logic [WE-1:0] exp_b
);
    localparam int XW = WE + 2;
    localparam logic signed [XW-1:0] ONE_S  = XW'(1);
    localparam logic signed [XW-1:0] BIAS_S = XW'(exp_bias(N));

    logic [N-4:0]           shifted;
    logic signed [XW-1:0]   e_ext;
    logic signed [XW-1:0]   run_s;
    logic signed [XW-1:0]   k_s;
    logic signed [XW-1:0]   x_raw;
    logic signed [XW-1:0]   x_true;

    // the tail starts two bits below the top of the body; skip run and terminator
    assign shifted = tail << (run_len - CW'(1));

    generate
        if (WES > 0) begin : g_es
            assign e_ext = $signed(XW'(shifted[N-4 -: WES]));
        end else begin : g_no_es
            assign e_ext = '0;
        end
    endgenerate

    assign frac   = shifted[WF-1:0];
    assign run_s  = $signed(XW'(run_len));
    assign k_s    = lead ? (run_s - ONE_S) : -run_s;
    assign x_raw  = (k_s <<< WES) + e_ext;
    // negative words: inverted scale keeps the raw fraction valid
    assign x_true = sign ? ~x_raw : x_raw;
    assign exp_b  = WE'(x_true + BIAS_S);
endmodule

// File: rtl/posit_decoder.sv
module posit_decoder
    import posit_dec_pkg::*;
#(
    parameter int N = 16,
    localparam int WF = frac_width(N),
    localparam int WE = exp_width(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [N-1:0]  in_posit,
    output logic          out_valid,
    output logic          out_nar,
    output logic          out_sign,
    output logic          out_imp,
    output logic [WF-1:0] out_frac,
    output logic [WE-1:0] out_exp,
    output logic          out_guard,
    output logic          out_sticky
);
    localparam int CW = run_width(N - 1);
    localparam logic [WE-1:0] MAX_E   = WE'(exp_max(N));
    localparam logic [N-1:0]  NAR_PAT = {1'b1, {(N-1){1'b0}}};

    typedef struct packed {
        logic          nar;
        logic          sign;
        logic          imp;
        logic [WF-1:0] frac;
        logic [WE-1:0] expo;
        logic          guard;
        logic          sticky;
    } pval_t;

    pcls_e         cls;
    logic          lead;
    logic [CW-1:0] run_len;
    logic [WF-1:0] frac_w;
    logic [WE-1:0] exp_w;
    pval_t         d_val;
    pval_t         q_val;
    logic          q_valid;

    posit_special_detect #(.N(N)) special_i (
        .word (in_posit),
        .cls  (cls)
    );

    posit_run_counter #(.W(N - 1)) run_i (
        .vec     (in_posit[N-2:0]),
        .lead    (lead),
        .run_len (run_len)
    );

    posit_field_align #(.N(N)) align_i (
        .sign    (in_posit[N-1]),
        .lead    (lead),
        .run_len (run_len),
        .tail    (in_posit[N-4:0]),
        .frac    (frac_w),
        .exp_b   (exp_w)
    );

    always_comb begin
        d_val = '0;
        unique case (cls)
            PCLS_NAR: begin
                d_val.nar  = 1'b1;
                d_val.sign = 1'b1;
            end
            PCLS_ZERO: d_val = '0;
            default: begin
                d_val.sign = in_posit[N-1];
                d_val.imp  = ~in_posit[N-1];
                d_val.frac = frac_w;
                d_val.expo = exp_w;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_val   <= '0;
        end else begin
            q_valid <= in_valid;
            if (in_valid) q_val <= d_val;
        end
    end

    assign out_valid  = q_valid;
    assign out_nar    = q_val.nar;
    assign out_sign   = q_val.sign;
    assign out_imp    = q_val.imp;
    assign out_frac   = q_val.frac;
    assign out_exp    = q_val.expo;
    assign out_guard  = q_val.guard;
    assign out_sticky = q_val.sticky;

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_follows_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_nar_pattern_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_posit == NAR_PAT) |=> (out_nar && out_sign && !out_imp));
    assert_nar_source_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_nar) |-> ($past(in_posit) == NAR_PAT));
    assert_zero_fields_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_posit == '0) |=>
            (!out_nar && !out_sign && !out_imp && out_frac == '0 && out_exp == '0));
    assert_positive_imp_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_posit[N-1] && in_posit != '0) |=> (!out_sign && out_imp));
    assert_negative_imp_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_posit[N-1] && in_posit[N-2:0] != '0) |=> (out_sign && !out_imp));
    assert_exp_range_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_exp <= MAX_E));
endmodule

// File: tb/posit_decoder_tb_top.sv
module posit_decoder_tb_top;

    typedef struct {
        int  code;
        bit  nar;
        bit  zero;
        real val;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        iv16 = 1'b0, iv8 = 1'b0;
    logic [15:0] p16 = '0;
    logic [7:0]  p8  = '0;

    logic        o16_valid, o16_nar, o16_sign, o16_imp, o16_guard, o16_sticky;
    logic [11:0] o16_frac;
    logic [5:0]  o16_exp;
    logic        o8_valid, o8_nar, o8_sign, o8_imp, o8_guard, o8_sticky;
    logic [4:0]  o8_frac;
    logic [3:0]  o8_exp;

    int nchk  = 0;
    int nfail = 0;
    exp_t q16[$];
    exp_t q8[$];
    logic v16_d = 1'b0, v8_d = 1'b0;

    posit_decoder #(.N(16)) dut_i (
        .clk(clk), .rst(rst), .in_valid(iv16), .in_posit(p16),
        .out_valid(o16_valid), .out_nar(o16_nar), .out_sign(o16_sign),
        .out_imp(o16_imp), .out_frac(o16_frac), .out_exp(o16_exp),
        .out_guard(o16_guard), .out_sticky(o16_sticky)
    );

    posit_decoder #(.N(8)) dut8_i (
        .clk(clk), .rst(rst), .in_valid(iv8), .in_posit(p8),
        .out_valid(o8_valid), .out_nar(o8_nar), .out_sign(o8_sign),
        .out_imp(o8_imp), .out_frac(o8_frac), .out_exp(o8_exp),
        .out_guard(o8_guard), .out_sticky(o8_sticky)
    );

    function automatic real pow2(input int e);
        real r = 1.0;
        if (e >= 0) for (int j = 0; j < e; j++) r = r * 2.0;
        else        for (int j = 0; j < -e; j++) r = r / 2.0;
        return r;
    endfunction

    // behavioural posit-to-real model (sign-magnitude decode)
    function automatic exp_t ref_item(input int n, input int wes, input int code);
        exp_t it;
        int mask, mag, r, m, idx, k, e;
        real f, w;
        mask = (1 << n) - 1;
        it.code = code; it.nar = 0; it.zero = 0; it.val = 0.0;
        if (code == 0) begin it.zero = 1; return it; end
        if (code == (1 << (n - 1))) begin it.nar = 1; return it; end
        mag = ((code >> (n - 1)) & 1) ? ((-code) & mask) : code;
        r = (mag >> (n - 2)) & 1;
        m = 0; idx = n - 2;
        while (idx >= 0 && ((mag >> idx) & 1) == r) begin m++; idx--; end
        idx--;
        k = r ? m - 1 : -m;
        e = 0;
        for (int j = 0; j < wes; j++) begin
            e = e * 2 + ((idx >= 0) ? ((mag >> idx) & 1) : 0);
            idx--;
        end
        f = 1.0; w = 0.5;
        while (idx >= 0) begin
            if ((mag >> idx) & 1) f = f + w;
            w = w / 2.0; idx--;
        end
        it.val = f * pow2(k * (1 << wes) + e);
        if ((code >> (n - 1)) & 1) it.val = -it.val;
        return it;
    endfunction

    task automatic chk(input bit ok, input string msg);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic compare(input exp_t it, input int n, input int wf, input int bias,
                           input bit nar, input bit s, input bit imp,
                           input int f, input int e, input bit g, input bit st);
        real dv;
        chk(!g && !st, $sformatf("R7 N=%0d code=%h guard/sticky got %b%b expected 00",
                                 n, it.code, g, st));
        if (it.nar) begin
            chk(nar && s && !imp && f == 0 && e == 0,
                $sformatf("R1 N=%0d code=%h got nar=%b s=%b i=%b f=%0d e=%0d expected 1 1 0 0 0",
                          n, it.code, nar, s, imp, f, e));
        end else begin
            chk(!nar, $sformatf("R1 N=%0d code=%h nar got %b expected 0", n, it.code, nar));
        end
        if (it.zero) begin
            chk(!s && !imp && f == 0 && e == 0,
                $sformatf("R2 N=%0d code=%h got s=%b i=%b f=%0d e=%0d expected 0 0 0 0",
                          n, it.code, s, imp, f, e));
        end else if (!it.nar) begin
            if (it.val > 0.0)
                chk(!s && imp, $sformatf("R3 N=%0d code=%h got s=%b i=%b expected 0 1",
                                         n, it.code, s, imp));
            else
                chk(s && !imp, $sformatf("R4 N=%0d code=%h got s=%b i=%b expected 1 0",
                                         n, it.code, s, imp));
            dv = (-2.0 * s + imp + real'(f) * pow2(-wf)) * pow2(e - bias);
            chk(dv == it.val, $sformatf("R5 N=%0d code=%h value got %g expected %g",
                                        n, it.code, dv, it.val));
            chk(e <= 2 * bias - 1, $sformatf("R6 N=%0d code=%h exp got %0d expected <= %0d",
                                             n, it.code, e, 2 * bias - 1));
        end
    endtask

    always @(posedge clk) begin
        v16_d <= rst ? 1'b0 : iv16;
        v8_d  <= rst ? 1'b0 : iv8;
    end

    // monitor: compare valid timing and pop the scoreboard
    always @(negedge clk) begin
        exp_t it;
        if (!rst) begin
            chk(o16_valid == v16_d, $sformatf("R8 N=16 out_valid got %b expected %b", o16_valid, v16_d));
            chk(o8_valid == v8_d,   $sformatf("R8 N=8 out_valid got %b expected %b", o8_valid, v8_d));
            if (o16_valid) begin
                if (q16.size() == 0) chk(1'b0, "R8 N=16 output with empty scoreboard got 1 expected 0");
                else begin
                    it = q16.pop_front();
                    compare(it, 16, 12, 29, o16_nar, o16_sign, o16_imp,
                            int'(o16_frac), int'(o16_exp), o16_guard, o16_sticky);
                end
            end
            if (o8_valid) begin
                if (q8.size() == 0) chk(1'b0, "R8 N=8 output with empty scoreboard got 1 expected 0");
                else begin
                    it = q8.pop_front();
                    compare(it, 8, 5, 7, o8_nar, o8_sign, o8_imp,
                            int'(o8_frac), int'(o8_exp), o8_guard, o8_sticky);
                end
            end
        end
    end

    // driver
    initial begin
        repeat (2) @(negedge clk);
        iv16 = 1'b1; p16 = 16'h4000; iv8 = 1'b1; p8 = 8'h40;
        repeat (2) begin
            @(negedge clk);
            chk(!o16_valid && !o8_valid,
                $sformatf("R9 valid under reset got %b%b expected 00", o16_valid, o8_valid));
        end
        iv16 = 1'b0; iv8 = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            iv16 = 1'b1; p16 = 16'(i);
            q16.push_back(ref_item(16, 1, i));
            if (i < 256) begin
                iv8 = 1'b1; p8 = 8'(i);
                q8.push_back(ref_item(8, 0, i));
            end else begin
                iv8 = 1'b0;
            end
            if (i % 97 == 96) begin
                @(negedge clk);
                iv16 = 1'b0; iv8 = 1'b0;
            end
        end
        @(negedge clk);
        iv16 = 1'b0; iv8 = 1'b0;
        repeat (4) @(negedge clk);
        chk(q16.size() == 0 && q8.size() == 0,
            $sformatf("R8 scoreboard left %0d/%0d expected 0/0", q16.size(), q8.size()));
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL R8 watchdog expired got running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule